// File: doc/BRIEF.md
# Escaped Frame Decoder with In-Band Command Extraction

This block sits behind a UART receiver on a chip-to-chip message link. It takes one raw byte per accepted cycle and rebuilds the framed messages carried in that stream. Frame delimiters are removed and escape pairs are undone. The recovered header and payload bytes leave as a stream marked with first and last flags. Single-byte link commands for connection setup and wake/sleep handshaking can appear anywhere in the same stream. They are pulled out and reported on a one-hot control output, and the frame around them is left intact.

Each completed frame is checked against the length field in its 8-byte header. At the closing marker the block pulses flags for a bad escape pair or a length mismatch. An opening marker that arrives inside a frame drops the partial frame, raises a resynchronisation flag and starts collecting a new frame. CRC checking and message storage belong to the consumer.

To produce the last flag, the block holds back one decoded byte. Each byte is therefore released when the next decoded byte arrives, or at the closing marker, and every output appears one clock after the input byte that caused it.

Top module: `rx_deframer`

## Requirements
- R1: Byte 0x7F opens a frame and byte 0x70 closes it. Neither is delivered as data, and the decoded bytes between them leave on `out_data` in arrival order. The final byte of a frame is delivered in the cycle after the closing byte is accepted.
- R2: Inside a frame, byte 0x7C followed by a byte in 0x50..0x5F delivers that second byte XOR 0x20 as a single data byte.
- R3: Raw codes map one cycle later to a one-hot bit of `ctrl_onehot`: 0x7E bit 0 (connect request), 0x7D bit 1 (connect ack), 0x79 bit 2 (wake request A), 0x78 bit 3 (wake ack A), 0x75 bit 4 (wake request B), 0x74 bit 5 (wake ack B), 0x77 bit 6 (allow sleep). A code is reported both inside and outside a frame, and inside a frame it neither adds nor removes data bytes.
- R4: `out_first` is high only with the first decoded byte of a frame and `out_last` only with the final one. Both flags are high together for a one-byte frame.
- R5: A 0x7F accepted inside a frame discards the not-yet-delivered byte, gives a one-cycle `err_resync` pulse with no `out_valid`, and opens a new frame.
- R6: Inside a frame, an escape followed by a byte outside 0x50..0x5F makes that frame corrupt. A following byte below 0x70 is dropped. A following byte from 0x70..0x7F keeps its raw meaning. `err_escape` pulses in the cycle the frame's final byte is delivered, which is the cycle after the close.
- R7: The header's length field is the 16-bit value of decoded bytes 6 (low) and 7 (high), counting from 0. `err_length` pulses at the close when the decoded byte count is below 8 or differs from that value. This includes an empty frame.
- R8: Data bytes, escapes and 0x70 received outside a frame produce no output and no error flag. The codes 0x71-0x73, 0x76, 0x7A and 0x7B are discarded everywhere.
- R9: While `rst_n` is low, every output is 0.
- R10: Cycles with `in_valid` low change nothing, so idle gaps inside a frame leave the decoded result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Raw byte present this cycle |
| in_byte | input | 8 | Raw received byte |
| out_valid | output | 1 | Decoded data byte valid |
| out_data | output | 8 | Decoded data byte |
| out_first | output | 1 | First byte of a frame |
| out_last | output | 1 | Final byte of a frame |
| ctrl_onehot | output | 7 | One-cycle pulse per received command code |
| err_resync | output | 1 | Frame dropped by an inner start marker |
| err_escape | output | 1 | Closed frame held a bad escape pair |
| err_length | output | 1 | Closed frame's byte count disagrees with its length field |

## Verification
The bench sends a payload holding the values 0x7F and 0x70. A decoder that does not undo escapes would deliver them as 0x5F and 0x50, or would cut the frame short. It places command codes inside a frame and right after an escape: a decoder that leaks them into the data would break the length check or lose the control pulse. It sends a restart in the middle of a frame, an empty frame, a one-byte frame and a mismatched length, which catches off-by-one counting, a missing drop of the held byte and a misplaced last flag. Idle gaps, stray bytes outside frames and escape-then-data-byte corruption complete the set.

// File: rtl/rx_deframer_pkg.sv
package rx_deframer_pkg;
  localparam logic [7:0] CODE_OPEN  = 8'h7F;
  localparam logic [7:0] CODE_CLOSE = 8'h70;
  localparam logic [7:0] CODE_ESC   = 8'h7C;
  localparam logic [7:0] ESC_XOR    = 8'h20;
  localparam logic [3:0] CODE_NIB   = 4'h7;
  localparam logic [3:0] ESCD_NIB   = 4'h5;
  localparam int         NCMD       = 7;

  typedef struct packed {
    logic open;
    logic close;
    logic esc;
    logic code;   // any other 0x7x byte
    logic data;   // byte below 0x70 or above 0x7F
  } byte_cls_t;

  function automatic logic [NCMD-1:0] cmd_map(input logic [7:0] b);
    logic [NCMD-1:0] oh;
    oh = '0;
    case (b)
      8'h7E: oh[0] = 1'b1;
      8'h7D: oh[1] = 1'b1;
      8'h79: oh[2] = 1'b1;
      8'h78: oh[3] = 1'b1;
      8'h75: oh[4] = 1'b1;
      8'h74: oh[5] = 1'b1;
      8'h77: oh[6] = 1'b1;
      default: oh = '0;
    endcase
    return oh;
  endfunction
endpackage

// File: rtl/rx_byte_classify.sv
module rx_byte_classify
  import rx_deframer_pkg::*;
(
  input  logic            vld,
  input  logic [7:0]      byte_i,
  output byte_cls_t       cls,
  output logic [NCMD-1:0] cmd_oh
);
  logic is_code;

  always_comb begin
    is_code    = (byte_i[7:4] == CODE_NIB);
    cls.open   = vld && (byte_i == CODE_OPEN);
    cls.close  = vld && (byte_i == CODE_CLOSE);
    cls.esc    = vld && (byte_i == CODE_ESC);
    cls.code   = vld && is_code && !cls.open && !cls.close && !cls.esc;
    cls.data   = vld && !is_code;
    cmd_oh     = vld ? cmd_map(byte_i) : '0;
  end
endmodule

// File: rtl/rx_unescape.sv
module rx_unescape
  import rx_deframer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  byte_cls_t  cls,
  input  logic [7:0] byte_i,
  output logic       dec_vld,
  output logic [7:0] dec_byte,
  output logic       ev_open,
  output logic       ev_resync,
  output logic       ev_close,
  output logic       corrupt_now,
  output logic       in_frame
);
  logic esc_pend, corrupt;
  logic in_frame_n, esc_pend_n, corrupt_n, bad;

  always_comb begin
    dec_vld    = 1'b0;
    dec_byte   = byte_i;
    ev_open    = 1'b0;
    ev_resync  = 1'b0;
    ev_close   = 1'b0;
    bad        = 1'b0;
    in_frame_n = in_frame;
    esc_pend_n = esc_pend;
    corrupt_n  = corrupt;
    if (cls.open) begin
      ev_open    = 1'b1;
      ev_resync  = in_frame;
      in_frame_n = 1'b1;
      esc_pend_n = 1'b0;
      corrupt_n  = 1'b0;
    end else if (in_frame) begin
      if (esc_pend && (cls.close || cls.esc || cls.code)) begin
        bad        = 1'b1;
        esc_pend_n = 1'b0;
      end
      if (cls.close) begin
        ev_close   = 1'b1;
        in_frame_n = 1'b0;
        esc_pend_n = 1'b0;
      end else if (cls.esc) begin
        esc_pend_n = 1'b1;
      end else if (cls.data) begin
        esc_pend_n = 1'b0;
        if (!esc_pend) begin
          dec_vld = 1'b1;
        end else if (byte_i[7:4] == ESCD_NIB) begin
          dec_vld  = 1'b1;
          dec_byte = byte_i ^ ESC_XOR;
        end else begin
          bad = 1'b1;
        end
      end
      corrupt_n = corrupt || bad;
    end
    corrupt_now = corrupt || bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      esc_pend <= 1'b0;
      corrupt  <= 1'b0;
    end else if (in_valid) begin
      in_frame <= in_frame_n;
      esc_pend <= esc_pend_n;
      corrupt  <= corrupt_n;
    end
  end

  // R2
  esc_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    esc_pend |-> in_frame);
endmodule

// File: rtl/rx_len_check.sv
module rx_len_check #(
  parameter int CNT_W   = 16,
  parameter int HDR_LEN = 8,
  parameter int LEN_POS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_open,
  input  logic       dec_vld,
  input  logic [7:0] dec_byte,
  output logic       first_o,
  output logic       len_err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] POS_LO  = CNT_W'(LEN_POS);
  localparam logic [CNT_W-1:0] POS_HI  = CNT_W'(LEN_POS + 1);
  localparam logic [CNT_W-1:0] HDR_C   = CNT_W'(HDR_LEN);

  logic [CNT_W-1:0] cnt, cnt_n;
  logic [15:0]      len_f, len_n;

  always_comb begin
    cnt_n = cnt;
    len_n = len_f;
    if (ev_open) begin
      cnt_n = '0;
    end else if (dec_vld) begin
      if (cnt != CNT_MAX) cnt_n = cnt + 1'b1;
      if (cnt == POS_LO) len_n[7:0]  = dec_byte;
      if (cnt == POS_HI) len_n[15:8] = dec_byte;
    end
    first_o = (cnt == '0);
    len_err = (cnt < HDR_C) || (cnt != CNT_W'(len_f));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      len_f <= '0;
    end else if (ev_open || dec_vld) begin
      cnt   <= cnt_n;
      len_f <= len_n;
    end
  end

  // R7
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && !ev_open && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import rx_deframer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_first,
  output logic             out_last,
  output logic [NCMD-1:0]  ctrl_onehot,
  output logic             err_resync,
  output logic             err_escape,
  output logic             err_length
);
  byte_cls_t       cls;
  logic [NCMD-1:0] cmd_oh;
  logic            dec_vld, ev_open, ev_resync, ev_close, corrupt_now, in_frame;
  logic [7:0]      dec_byte;
  logic            first_o, len_err;

  rx_byte_classify u_cls (
    .vld(in_valid), .byte_i(in_byte), .cls(cls), .cmd_oh(cmd_oh)
  );

  rx_unescape u_unesc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cls(cls), .byte_i(in_byte),
    .dec_vld(dec_vld), .dec_byte(dec_byte), .ev_open(ev_open),
    .ev_resync(ev_resync), .ev_close(ev_close), .corrupt_now(corrupt_now),
    .in_frame(in_frame)
  );

  rx_len_check #(.CNT_W(CNT_W)) u_len (
    .clk(clk), .rst_n(rst_n), .ev_open(ev_open), .dec_vld(dec_vld),
    .dec_byte(dec_byte), .first_o(first_o), .len_err(len_err)
  );

  // one-byte hold so the final byte can carry the last flag
  logic       hold_vld, hold_first, hold_vld_n, hold_first_n;
  logic [7:0] hold_byte, hold_byte_n;
  logic       ov_n, of_n, ol_n, er_n, ee_n, el_n;
  logic [7:0] od_n;

  always_comb begin
    hold_vld_n   = hold_vld;
    hold_byte_n  = hold_byte;
    hold_first_n = hold_first;
    ov_n = 1'b0;
    od_n = hold_byte;
    of_n = hold_first;
    ol_n = 1'b0;
    er_n = ev_resync;
    ee_n = 1'b0;
    el_n = 1'b0;
    if (ev_open) begin
      hold_vld_n = 1'b0;
    end else if (ev_close) begin
      ov_n       = hold_vld;
      ol_n       = hold_vld;
      ee_n       = corrupt_now;
      el_n       = len_err;
      hold_vld_n = 1'b0;
    end else if (dec_vld) begin
      ov_n         = hold_vld;
      hold_vld_n   = 1'b1;
      hold_byte_n  = dec_byte;
      hold_first_n = first_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld   <= 1'b0;
      hold_byte  <= '0;
      hold_first <= 1'b0;
    end else if (in_valid) begin
      hold_vld   <= hold_vld_n;
      hold_byte  <= hold_byte_n;
      hold_first <= hold_first_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_first   <= 1'b0;
      out_last    <= 1'b0;
      ctrl_onehot <= '0;
      err_resync  <= 1'b0;
      err_escape  <= 1'b0;
      err_length  <= 1'b0;
    end else begin
      out_valid   <= ov_n;
      out_data    <= ov_n ? od_n : '0;
      out_first   <= ov_n && of_n;
      out_last    <= ol_n;
      ctrl_onehot <= cmd_oh;
      err_resync  <= er_n;
      err_escape  <= ee_n;
      err_length  <= el_n;
    end
  end

  // R4
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  // R5
  resync_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_resync |-> !out_valid);
  // R3
  ctrl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_onehot));
  // R10
  ctrl_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_onehot != '0) |-> $past(in_valid));
  // R1
  hold_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_vld |-> in_frame);
endmodule

// File: tb/rx_deframer_tb.sv
module rx_deframer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_byte;
  logic       out_valid, out_first, out_last;
  logic [7:0] out_data;
  logic [6:0] ctrl_onehot;
  logic       err_resync, err_escape, err_length;

  always #10 clk = ~clk;

  rx_deframer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
    .out_last(out_last), .ctrl_onehot(ctrl_onehot), .err_resync(err_resync),
    .err_escape(err_escape), .err_length(err_length)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] cap_d [0:63];
  bit         cap_f [0:63];
  bit         cap_l [0:63];
  int         ncap, c_res, c_esc, c_len;
  logic [6:0] cap_ctrl;
  bit         mon_on = 0;

  logic [7:0] exp_d [0:63];
  int         nexp;
  logic [7:0] pay [0:15];
  bit         gaps = 0;

  always @(negedge clk) if (mon_on) begin
    if (out_valid) begin
      if (ncap < 64) begin
        cap_d[ncap] = out_data; cap_f[ncap] = out_first; cap_l[ncap] = out_last;
      end
      ncap++;
    end
    cap_ctrl = cap_ctrl | ctrl_onehot;
    if (err_resync) c_res++;
    if (err_escape) c_esc++;
    if (err_length) c_len++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic clr();
    ncap = 0; c_res = 0; c_esc = 0; c_len = 0; cap_ctrl = '0; nexp = 0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
    if (gaps) idle(2);
  endtask

  task automatic put_dat(input logic [7:0] b);
    if (b[7:4] == 4'h7) begin put(8'h7C); put(b ^ 8'h20); end
    else put(b);
    exp_d[nexp] = b; nexp++;
  endtask

  task automatic put_hdr(input logic [15:0] lenv);
    for (int i = 0; i < 6; i++) put_dat(8'h00);
    put_dat(lenv[7:0]); put_dat(lenv[15:8]);
  endtask

  task automatic cmp_stream(input string req);
    chk(ncap == nexp, req, ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++) begin
      chk(cap_d[i] == exp_d[i], req, cap_d[i], exp_d[i]);
      chk(cap_f[i] == (i == 0), req, cap_f[i], i == 0);
      chk(cap_l[i] == (i == nexp - 1), req, cap_l[i], i == nexp - 1);
    end
  endtask

  task automatic cmp_err(input string req, input int r, input int e, input int l);
    chk(c_res == r, {req, " resync"}, c_res, r);
    chk(c_esc == e, {req, " escape"}, c_esc, e);
    chk(c_len == l, {req, " length"}, c_len, l);
  endtask

  // R1 R2 R4: frame with escaped marker values in its payload
  task automatic t_basic();
    clr();
    put(8'h7F); put_hdr(16'd12);
    put_dat(8'h01); put_dat(8'h7F); put_dat(8'h70); put_dat(8'h5A);
    put(8'h70); idle(3);
    cmp_stream("R1_R2_R4 basic");
    cmp_err("R1 basic", 0, 0, 0);
  endtask

  // R3: every command code outside a frame
  task automatic t_cmds();
    logic [7:0] codes [0:6];
    codes[0] = 8'h7E; codes[1] = 8'h7D; codes[2] = 8'h79; codes[3] = 8'h78;
    codes[4] = 8'h75; codes[5] = 8'h74; codes[6] = 8'h77;
    for (int i = 0; i < 7; i++) begin
      clr(); put(codes[i]); idle(2);
      chk(cap_ctrl == 7'(1 << i), "R3 cmd map", cap_ctrl, 1 << i);
    end
  endtask

  // R3: command inside a frame leaves data untouched
  task automatic t_cmd_in_frame();
    clr();
    put(8'h7F); put_hdr(16'd10);
    put_dat(8'h11); put(8'h79); put_dat(8'h22);
    put(8'h70); idle(3);
    cmp_stream("R3 cmd in frame");
    chk(cap_ctrl == 7'b0000100, "R3 cmd in frame ctrl", cap_ctrl, 4);
    cmp_err("R3 in frame", 0, 0, 0);
  endtask

  // R5: restart mid-frame
  task automatic t_resync();
    clr();
    put(8'h7F); put(8'h33);
    put(8'h7F); put_hdr(16'd8); put(8'h70); idle(3);
    cmp_stream("R5 resync");
    cmp_err("R5 resync", 1, 0, 0);
  endtask

  // R6: escape followed by ordinary byte
  task automatic t_bad_esc();
    clr();
    put(8'h7F); put_hdr(16'd9); put_dat(8'hAA);
    put(8'h7C); put(8'h01); put(8'h70); idle(3);
    cmp_stream("R6 bad escape");
    cmp_err("R6 bad escape", 0, 1, 0);
  endtask

  // R6 R3: escape followed by a command code
  task automatic t_esc_cmd();
    clr();
    put(8'h7F); put_hdr(16'd8);
    put(8'h7C); put(8'h7E); put(8'h70); idle(3);
    cmp_stream("R6 esc then cmd");
    chk(cap_ctrl == 7'b0000001, "R3 esc then cmd ctrl", cap_ctrl, 1);
    cmp_err("R6 esc then cmd", 0, 1, 0);
  endtask

  // R7: length field disagrees
  task automatic t_len_bad();
    clr();
    put(8'h7F); put_hdr(16'd10);
    put_dat(8'h01); put_dat(8'h02); put_dat(8'h03);
    put(8'h70); idle(3);
    cmp_stream("R7 len mismatch");
    cmp_err("R7 len mismatch", 0, 0, 1);
  endtask

  // R4 R7: one-byte frame, then empty frame
  task automatic t_short();
    clr();
    put(8'h7F); put_dat(8'h05); put(8'h70); idle(3);
    cmp_stream("R4 one-byte");
    cmp_err("R7 one-byte", 0, 0, 1);
    clr();
    put(8'h7F); put(8'h70); idle(3);
    chk(ncap == 0, "R7 empty data", ncap, 0);
    cmp_err("R7 empty", 0, 0, 1);
  endtask

  // R8: stray bytes outside frames
  task automatic t_outside();
    clr();
    put(8'h11); put(8'h22); put(8'h70); put(8'h7C); put(8'h55);
    put(8'h71); put(8'h7A); idle(3);
    chk(ncap == 0, "R8 outside data", ncap, 0);
    chk(cap_ctrl == 0, "R8 reserved codes", cap_ctrl, 0);
    cmp_err("R8 outside", 0, 0, 0);
  endtask

  // R10: idle gaps between every byte
  task automatic t_gaps();
    clr(); gaps = 1;
    put(8'h7F); put_hdr(16'd10); put_dat(8'h7C); put_dat(8'h44);
    put(8'h70); gaps = 0; idle(3);
    cmp_stream("R10 gaps");
    cmp_err("R10 gaps", 0, 0, 0);
  endtask

  initial begin
    in_valid = 1'b0; in_byte = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9
    chk(!out_valid && !out_first && !out_last && out_data == 0, "R9 data outs", out_valid, 0);
    chk(ctrl_onehot == 0 && !err_resync && !err_escape && !err_length, "R9 flag outs",
        ctrl_onehot, 0);
    rst_n = 1'b1; mon_on = 1;
    idle(2);
    t_basic(); t_cmds(); t_cmd_in_frame(); t_resync(); t_bad_esc();
    t_esc_cmd(); t_len_bad(); t_short(); t_outside(); t_gaps();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule